// File: doc/BRIEF.md
# ADC Conversion Control and Status Register

This block is the software-facing control and status byte of a successive-approximation analog-to-digital converter, together with the sequencing logic that starts and stops conversions. Software writes one 8-bit register to pick an input channel and to turn on the interrupt and repeat options. It reads the same register back to see whether a result is ready. The converter itself sits outside the block. It receives a one-cycle start pulse, a channel code and a power enable, and it answers with a one-cycle done pulse. A compare-enable and a compare-true qualifier come with each done pulse.

A conversion can be started in two ways. In software-trigger mode, any register write that names a real channel starts one. In hardware-trigger mode, an external trigger pulse starts one while the converter is idle. When the repeat option is off, the converter powers down after each result. When it is on, a new conversion starts in the same cycle that a result is accepted. Writing the all-ones channel code is the off switch: the converter powers down at once, and no further conversion follows. The ready flag clears on any write to the register and on a read of the low result byte. The interrupt line shows the flag whenever interrupts are enabled.

Top module: `adc_sc_top`

## Requirements
- R1: While reset is held and immediately after it, the register reads 0x1F (flag, interrupt enable and repeat enable 0, channel all ones), and `conv_pwr`, `conv_start` and `irq` are 0.
- R2: A write loads bits 6:0 (bit 6 interrupt enable, bit 5 repeat enable, bits 4:0 channel), and the value is visible on the next cycle. Bit 7 of the write data is ignored. A read returns {flag, interrupt enable, repeat enable, channel}, and `conv_chan` equals the stored channel.
- R3: On an accepted done pulse, the flag sets when `cmp_en` is 0. When `cmp_en` is 1, it sets only if `cmp_true` is 1.
- R4: The flag clears one cycle after any register write, and one cycle after a `rd_lo` strobe. If an accepted done pulse that sets the flag arrives in the same cycle as `rd_lo`, the flag ends up set.
- R5: `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R6: In software-trigger mode (`hw_mode`=0), a write whose channel is not 11111 gives a one-cycle `conv_start` and raises `conv_pwr` on the next cycle. A write during a running conversion aborts it and restarts it on the new channel.
- R7: With the repeat enable at 0, an accepted done pulse drops `conv_pwr` on the next cycle, and no new start is issued.
- R8: With the repeat enable at 1 and a channel other than 11111, every accepted done pulse issues a new `conv_start` on the next cycle, and `conv_pwr` stays high.
- R9: A write of channel 11111 drops `conv_pwr` on the next cycle and issues no start. A later done pulse is then ignored: it does not set the flag and does not start a conversion.
- R10: In hardware-trigger mode (`hw_mode`=1), writes start nothing. A `hw_trig` pulse while idle with a channel other than 11111 starts a conversion. A trigger while the channel is 11111 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_lo | input | 1 | Strobe: the low result byte is being read |
| rd_data | output | 8 | Register read value |
| hw_mode | input | 1 | 1 selects hardware trigger, 0 selects software trigger |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_done | input | 1 | Converter done pulse |
| cmp_en | input | 1 | Compare function enabled for this result |
| cmp_true | input | 1 | Compare condition met for this result |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 5 | Channel code to the converter |
| conv_pwr | output | 1 | Converter power / active enable |
| irq | output | 1 | Conversion complete interrupt |

## Verification
The assertions take for granted that the converter raises `conv_done` only while it is powered, that it never raises it in the cycle that carries a start pulse, and that the compare qualifiers are valid whenever `conv_done` is high. The stimulus keeps to this. Every done pulse is driven at least one full cycle after a start. The only done pulses driven while the converter is off are the deliberate ones in the off-switch test. All strobes are driven between clock edges and last exactly one cycle, so each pulse is seen by exactly one edge.

// File: rtl/adc_sc_pkg.sv
package adc_sc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_st_t;
endpackage

// File: rtl/adc_sc_rstsync.sv
module adc_sc_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/adc_sc_reg.sv
module adc_sc_reg #(
  parameter int CH_W = 5,
  localparam int REG_W = CH_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic            rd_lo,
  input  logic            done_v,
  input  logic            cmp_en,
  input  logic            cmp_true,
  output logic            flag,
  output logic            aien,
  output logic            adco,
  output logic [CH_W-1:0] chan
);
  logic            flag_d, aien_d, adco_d;
  logic [CH_W-1:0] chan_d;
  logic            flag_set;

  always_comb begin
    flag_set = done_v && (!cmp_en || cmp_true) && !wr_en;
    aien_d   = aien;
    adco_d   = adco;
    chan_d   = chan;
    if (wr_en) begin
      aien_d = wr_data[CH_W+1];
      adco_d = wr_data[CH_W];
      chan_d = wr_data[CH_W-1:0];
    end
    if (flag_set)            flag_d = 1'b1;
    else if (wr_en || rd_lo) flag_d = 1'b0;
    else                     flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      aien <= 1'b0;
      adco <= 1'b0;
      chan <= '1;
    end else begin
      flag <= flag_d;
      aien <= aien_d;
      adco <= adco_d;
      chan <= chan_d;
    end
  end

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(done_v && (!cmp_en || cmp_true)));
  p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !flag);
endmodule

// File: rtl/adc_sc_seq.sv
module adc_sc_seq
  import adc_sc_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            hw_mode,
  input  logic            hw_trig,
  input  logic            conv_done,
  input  logic            adco,
  input  logic [CH_W-1:0] chan,
  output logic            busy,
  output logic            conv_start,
  output logic            done_v
);
  localparam logic [CH_W-1:0] CH_OFF = '1;

  seq_st_t st_q, st_d;
  logic    start_d;
  logic    wr_off, start_sw, start_hw, start_rep;

  always_comb begin
    wr_off    = wr_en && (wr_chan == CH_OFF);
    done_v    = (st_q == SEQ_CONV) && conv_done && !wr_en;
    start_sw  = wr_en && !hw_mode && !wr_off;
    start_hw  = hw_mode && hw_trig && (st_q == SEQ_IDLE) && (chan != CH_OFF) && !wr_en;
    start_rep = done_v && adco && (chan != CH_OFF);
    st_d      = st_q;
    start_d   = 1'b0;
    if (wr_off) begin
      st_d = SEQ_IDLE;
    end else if (start_sw || start_hw || start_rep) begin
      st_d    = SEQ_CONV;
      start_d = 1'b1;
    end else if (wr_en || done_v) begin
      st_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SEQ_IDLE;
      conv_start <= 1'b0;
    end else begin
      st_q       <= st_d;
      conv_start <= start_d;
    end
  end

  assign busy = (st_q == SEQ_CONV);

  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v && !adco) |=> !busy);
  p_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v && adco && chan != CH_OFF) |=> (conv_start && busy));
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> (!busy && !conv_start));
  p_hw_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hw_mode) |=> !conv_start);
endmodule

// File: rtl/adc_sc_top.sv
module adc_sc_top #(
  parameter int CH_W = 5,
  localparam int REG_W = CH_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_lo,
  output logic [REG_W-1:0] rd_data,
  input  logic             hw_mode,
  input  logic             hw_trig,
  input  logic             conv_done,
  input  logic             cmp_en,
  input  logic             cmp_true,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic             conv_pwr,
  output logic             irq
);
  logic            rst_n_s;
  logic            flag, aien, adco, busy, done_v;
  logic [CH_W-1:0] chan;

  adc_sc_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  adc_sc_reg #(.CH_W(CH_W)) u_reg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_data(wr_data),
    .rd_lo(rd_lo), .done_v(done_v), .cmp_en(cmp_en), .cmp_true(cmp_true),
    .flag(flag), .aien(aien), .adco(adco), .chan(chan)
  );

  adc_sc_seq #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_chan(wr_data[CH_W-1:0]),
    .hw_mode(hw_mode), .hw_trig(hw_trig), .conv_done(conv_done),
    .adco(adco), .chan(chan), .busy(busy), .conv_start(conv_start),
    .done_v(done_v)
  );

  assign rd_data   = {flag, aien, adco, chan};
  assign conv_chan = chan;
  assign conv_pwr  = busy;
  assign irq       = flag && aien;

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> ($past(conv_done) || $past(wr_en)));
endmodule

// File: tb/tb_adc_sc_top.sv
module tb_adc_sc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_lo = 1'b0, hw_mode = 1'b0, hw_trig = 1'b0;
  logic       conv_done = 1'b0, cmp_en = 1'b0, cmp_true = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       conv_start, conv_pwr, irq;
  logic [4:0] conv_chan;
  int         errs = 0, chks = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  adc_sc_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_lo(rd_lo),
    .rd_data(rd_data), .hw_mode(hw_mode), .hw_trig(hw_trig),
    .conv_done(conv_done), .cmp_en(cmp_en), .cmp_true(cmp_true),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_pwr(conv_pwr),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic done(input logic ce, input logic ct, input logic rl);
    @(negedge clk); conv_done = 1'b1; cmp_en = ce; cmp_true = ct; rd_lo = rl;
    @(negedge clk); conv_done = 1'b0; cmp_en = 1'b0; cmp_true = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic rdlo();
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); rd_lo = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk); hw_trig = 1'b1;
    @(negedge clk); hw_trig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; chks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rd", rd_data, 8'h1F);
    chk("R1 reset pwr", {7'd0, conv_pwr}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 post rd", rd_data, 8'h1F);
    chk("R1 post irq/start/pwr", {5'd0, irq, conv_start, conv_pwr}, 8'd0);

    // R2 / R6 sweep: all write values in software-trigger mode
    for (int v = 0; v < 256; v++) begin
      logic on;
      wr(v[7:0]);
      on = (v[4:0] != 5'h1F);
      chk("R2 readback", rd_data, {1'b0, v[6:0]});
      chk("R2 conv_chan", {3'd0, conv_chan}, {3'd0, v[4:0]});
      chk("R6 start/pwr", {6'd0, conv_start, conv_pwr}, {6'd0, on, on});
    end
    wr(8'h1F);

    // R3 / R5 / R7 / R4 compare sweep in single mode
    for (int k = 0; k < 8; k++) begin
      logic ce, ct, ie, fl;
      ce = k[0]; ct = k[1]; ie = k[2];
      fl = !ce || ct;
      wr({1'b0, ie, 1'b0, 5'd3});
      @(negedge clk);
      done(ce, ct, 1'b0);
      chk("R3 flag", {7'd0, rd_data[7]}, {7'd0, fl});
      chk("R5 irq", {7'd0, irq}, {7'd0, fl && ie});
      chk("R7 single end", {6'd0, conv_pwr, conv_start}, 8'd0);
      rdlo();
      chk("R4 read clears", {7'd0, rd_data[7]}, 8'd0);
    end

    // R4 write clears; R2 bit7 ignored
    wr(8'h43); @(negedge clk); done(1'b0, 1'b0, 1'b0);
    chk("R4 flag set before write", {7'd0, rd_data[7]}, 8'd1);
    wr(8'h83);
    chk("R4 write clears / R2 bit7 ignored", rd_data, 8'h03);
    // R4 done and read in same cycle: flag ends set
    @(negedge clk); done(1'b0, 1'b0, 1'b1);
    chk("R4 set beats read-clear", {7'd0, rd_data[7]}, 8'd1);

    // R6 restart on new channel mid-conversion
    wr(8'h02); @(negedge clk);
    wr(8'h04);
    chk("R6 restart start", {7'd0, conv_start}, 8'd1);
    chk("R6 restart chan", {3'd0, conv_chan}, 8'd4);

    // R8 continuous
    wr(8'h25);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      done(1'b0, 1'b0, 1'b0);
      chk("R8 restart", {6'd0, conv_start, conv_pwr}, 8'd3);
      chk("R8 flag", {7'd0, rd_data[7]}, 8'd1);
    end
    // R9 off switch
    wr(8'h3F);
    chk("R9 off", {6'd0, conv_start, conv_pwr}, 8'd0);
    done(1'b0, 1'b0, 1'b0);
    chk("R9 done ignored", {5'd0, rd_data[7], conv_start, conv_pwr}, 8'd0);

    // R10 hardware trigger mode
    hw_mode = 1'b1;
    wr(8'h07);
    chk("R10 write no start", {6'd0, conv_start, conv_pwr}, 8'd0);
    trig();
    chk("R10 trig start", {6'd0, conv_start, conv_pwr}, 8'd3);
    @(negedge clk); done(1'b0, 1'b0, 1'b0);
    chk("R10 R7 done idle", {6'd0, conv_start, conv_pwr}, 8'd0);
    wr(8'h1F);
    trig();
    chk("R10 trig off chan", {6'd0, conv_start, conv_pwr}, 8'd0);
    chk("R10 reg kept", rd_data, 8'h1F);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule